// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block sits on the read path of a small byte-wide nonvolatile array and supplies what a host sees while an embedded write or erase is under way. Command decoding happens upstream: once a command sequence is complete it delivers a one-cycle `start` together with the operation kind, the target address, the byte to program and a busy length in clock cycles. From then until the operation retires, every read strobe returns a polled status byte instead of array contents. Bit 7 reports completion: it is the inverse of bit 7 of the byte being programmed, or 0 during an erase. Bit 6 flips on each read. When the operation retires, the block commits it to the array. A program ANDs the new byte into the stored byte. An erase fills a block, or the whole array, with ones.

The sequencer is a four-state machine. IDLE waits for an accepted start. PROG_WAIT and ERASE_WAIT count the busy length down. COMMIT applies the update for one cycle. Its transitions are as follows. IDLE→PROG_WAIT is taken on an accepted program start. IDLE→ERASE_WAIT is taken on an accepted block or chip erase start. PROG_WAIT→COMMIT and ERASE_WAIT→COMMIT are taken when the down-counter is zero. COMMIT→IDLE is always taken.

A read is started by a rising edge of `rd_stb` seen at a clock edge. `rd_data` is loaded at that same edge and holds its value until the next read.

Top module: `flash_status_rpt`

## Requirements
- R1: After reset `busy` is 0 and `rd_data` is 0x00, and every array byte reads 0xFF.
- R2: A start accepted in IDLE raises `busy` at the accepting clock edge. `busy` then stays high for exactly `op_len`+2 cycles.
- R3: During a program operation (op_kind 0), a read returns {~D[7], T, 6'b0}. D is the byte being programmed and T is the toggle bit.
- R4: During a block erase (op_kind 1) or chip erase (op_kind 2), bit 7 of a read is 0 and bits 5..0 are 0. After an erase, the erased bytes read 1 on bit 7.
- R5: The toggle bit is 0 on the first read after an accepted start. It inverts on every further read while busy.
- R6: A start is ignored while `busy` is high, and also when op_kind is 3. An ignored start changes neither the running operation nor the toggle sequence.
- R7: A completed program leaves the stored byte equal to old AND D, so it can only clear bits.
- R8: A block erase writes 0xFF to every byte whose top two address bits (the block index) match those of `op_addr`. Bytes in other blocks are left unchanged.
- R9: A chip erase writes 0xFF to every byte of the array.
- R10: While idle, a read returns the true stored byte on all eight bits. Repeated reads of the same byte return the same value, so bit 6 does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_kind | input | 2 | 0 program, 1 block erase, 2 chip erase, 3 none |
| op_addr | input | ADDR_W | Byte address (program) or any address in the block (block erase) |
| op_data | input | 8 | Byte to program |
| op_len | input | CNT_W | Busy length parameter, in cycles |
| rd_stb | input | 1 | Read strobe; a rising edge starts one read |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result: status while busy, array data while idle |
| busy | output | 1 | High while an operation is in progress |

## Verification
The assertions assume that `start` arrives only as a one-cycle pulse. They also assume that `op_kind`, `op_addr` and `op_data` are valid in the cycle where `start` is high. The bench drives every input at the falling clock edge and holds `start` for exactly one cycle. Each read strobe lasts one high cycle followed by one low cycle, so every read is a separate rising edge. The busy lengths are chosen so that all polled reads and the deliberately ignored start fall inside the busy window, before COMMIT.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_BLK_ERASE  = 2'd1,
        OP_CHIP_ERASE = 2'd2,
        OP_NONE       = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PROG_WAIT,
        S_ERASE_WAIT,
        S_COMMIT
    } seq_state_e;
endpackage

// File: rtl/fsr_seq.sv
module fsr_seq
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [CNT_W-1:0]  op_len,
    output logic              busy,
    output logic              commit,
    output logic              accept,
    output op_e               kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        data_q
);
    seq_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    op_e kind_in;

    assign kind_in = op_e'(op_kind);
    assign accept  = (state_q == S_IDLE) && start && (kind_in != OP_NONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept)
                    state_d = (kind_in == OP_PROG) ? S_PROG_WAIT : S_ERASE_WAIT;
            end
            S_PROG_WAIT,
            S_ERASE_WAIT: begin
                if (cnt_q == '0)
                    state_d = S_COMMIT;
            end
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            kind_q <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            cnt_q  <= op_len;
            kind_q <= kind_in;
            addr_q <= op_addr;
            data_q <= op_data;
        end else if ((state_q == S_PROG_WAIT || state_q == S_ERASE_WAIT) && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy   = (state_q != S_IDLE);
        commit = (state_q == S_COMMIT);
    end

    a_r2_accept_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    a_r2_commit_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
    a_r6_op_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(kind_q) && $stable(addr_q) && $stable(data_q)));
    a_r6_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);
endmodule

// File: rtl/fsr_store.sv
module fsr_store
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_e               kind_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [7:0]        data_q,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        mem_rd
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SHIFT = ADDR_W - BLK_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            if (kind_q == OP_PROG) begin
                mem[addr_q] <= mem[addr_q] & data_q;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (kind_q == OP_CHIP_ERASE ||
                        (ADDR_W'(i) >> SHIFT) == (addr_q >> SHIFT))
                        mem[i] <= 8'hFF;
                end
            end
        end
    end

    assign mem_rd = mem[rd_addr];

    a_r7_program_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind_q == OP_PROG) |=>
            ((mem[$past(addr_q)] & ~$past(mem[addr_q])) == 8'h00));
    a_r9_chip_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind_q == OP_CHIP_ERASE) |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/fsr_readout.sv
module fsr_readout
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_stb,
    input  logic       busy,
    input  logic       accept,
    input  op_e        kind_q,
    input  logic [7:0] data_q,
    input  logic [7:0] mem_rd,
    output logic [7:0] rd_data
);
    logic stb_q;
    logic tgl_q;
    logic rise;
    logic [7:0] status;

    assign rise = rd_stb && !stb_q;

    always_comb begin
        status    = 8'h00;
        status[7] = (kind_q == OP_PROG) ? ~data_q[7] : 1'b0;
        status[6] = tgl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q   <= 1'b0;
            tgl_q   <= 1'b0;
            rd_data <= 8'h00;
        end else begin
            stb_q <= rd_stb;
            if (accept)
                tgl_q <= 1'b0;
            else if (rise && busy)
                tgl_q <= ~tgl_q;
            if (rise)
                rd_data <= busy ? status : mem_rd;
        end
    end

    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy) |=> (tgl_q != $past(tgl_q)));
    a_r5_toggle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !tgl_q);
    a_r3_prog_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy && kind_q == OP_PROG) |=> (rd_data[7] == ~$past(data_q[7])));
    a_r4_erase_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy && kind_q != OP_PROG) |=> (rd_data[7] == 1'b0 && rd_data[5:0] == 6'd0));
    a_r10_idle_true_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !busy) |=> (rd_data == $past(mem_rd)));
endmodule

// File: rtl/flash_status_rpt.sv
module flash_status_rpt
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 2,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [CNT_W-1:0]  op_len,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    logic              commit;
    logic              accept;
    op_e               kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [7:0]        mem_rd;

    fsr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .op_len(op_len),
        .busy(busy), .commit(commit), .accept(accept),
        .kind_q(kind_q), .addr_q(addr_q), .data_q(data_q)
    );

    fsr_store #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) store_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .kind_q(kind_q),
        .addr_q(addr_q), .data_q(data_q), .rd_addr(rd_addr), .mem_rd(mem_rd)
    );

    fsr_readout readout_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy),
        .accept(accept), .kind_q(kind_q), .data_q(data_q),
        .mem_rd(mem_rd), .rd_data(rd_data)
    );
endmodule

// File: tb/flash_status_rpt_tb.sv
module flash_status_rpt_tb_top;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        op_kind = 2'd0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic [7:0]        op_data = 8'h00;
    logic [CNT_W-1:0]  op_len = '0;
    logic              rd_stb = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              busy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       sample_ev;

    flash_status_rpt #(.ADDR_W(ADDR_W), .BLK_W(2), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .op_len(op_len),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read results and compares them with rd_data.
    initial forever begin
        @(sample_ev);
        while (exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, rd_data, e);
        end
    end

    // Driver: one read, expected value pushed to the scoreboard.
    task automatic read_exp(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        rd_stb  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> sample_ev;
    endtask

    task automatic start_op(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                            input logic [7:0] d, input logic [CNT_W-1:0] n);
        @(negedge clk);
        start = 1'b1; op_kind = k; op_addr = a; op_data = d; op_len = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 rd_data after reset", rd_data, 8'h00);
        read_exp(6'd0,  8'hFF, "R1 erased at reset addr0");
        read_exp(6'd63, 8'hFF, "R1 erased at reset addr63");

        // R6: op_kind 3 is ignored
        start_op(2'd3, 6'd5, 8'h00, 8'd4);
        check("R6 kind 3 ignored", busy, 0);
        read_exp(6'd5, 8'hFF, "R6 kind 3 left array");

        // R2: busy length op_len+2
        start_op(2'd0, 6'd5, 8'h3C, 8'd10);
        check("R2 busy raised", busy, 1);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R2 busy length", n, 12);
        read_exp(6'd5, 8'h3C, "R7 first program");

        // R3/R5/R6: polled program with an ignored chip erase in the middle
        start_op(2'd0, 6'd5, 8'hF0, 8'd30);
        read_exp(6'd5, 8'h00, "R3 prog D7=1 read1 R5");
        read_exp(6'd5, 8'h40, "R3 prog read2 R5");
        read_exp(6'd5, 8'h00, "R5 prog read3");
        start_op(2'd2, 6'd0, 8'h00, 8'd1);
        read_exp(6'd5, 8'h40, "R6 toggle unaffected by ignored start");
        read_exp(6'd9, 8'h00, "R5 prog read5");
        wait_idle();
        read_exp(6'd5, 8'h30, "R7 old AND new");
        read_exp(6'd6, 8'hFF, "R6 ignored chip erase did nothing");

        start_op(2'd0, 6'd20, 8'h12, 8'd20);
        read_exp(6'd20, 8'h80, "R3 prog D7=0 read1");
        read_exp(6'd20, 8'hC0, "R3 prog D7=0 read2");
        wait_idle();
        read_exp(6'd20, 8'h12, "R7 program into erased byte");

        start_op(2'd0, 6'd40, 8'h55, 8'd2); wait_idle();
        start_op(2'd0, 6'd50, 8'h0F, 8'd2); wait_idle();
        start_op(2'd0, 6'd3,  8'h00, 8'd2); wait_idle();

        // R4/R8: block erase of block 1 (addresses 16..31)
        start_op(2'd1, 6'd17, 8'h00, 8'd20);
        read_exp(6'd20, 8'h00, "R4 erase read1");
        read_exp(6'd20, 8'h40, "R4 erase read2 R5");
        read_exp(6'd20, 8'h00, "R4 erase read3");
        wait_idle();
        read_exp(6'd20, 8'hFF, "R8 block erased, R4 bit7 now 1");
        read_exp(6'd5,  8'h30, "R8 block 0 untouched");
        read_exp(6'd40, 8'h55, "R8 block 2 untouched");
        read_exp(6'd3,  8'h00, "R8 block 0 zero byte untouched");

        // R9: chip erase
        start_op(2'd2, 6'd0, 8'h00, 8'd5);
        read_exp(6'd40, 8'h00, "R4 chip erase read1");
        wait_idle();
        read_exp(6'd5,  8'hFF, "R9 chip erase addr5");
        read_exp(6'd40, 8'hFF, "R9 chip erase addr40");
        read_exp(6'd50, 8'hFF, "R9 chip erase addr50");
        read_exp(6'd3,  8'hFF, "R9 chip erase addr3");

        // R10: idle reads are stable, bit 6 does not toggle
        start_op(2'd0, 6'd9, 8'h8B, 8'd3); wait_idle();
        read_exp(6'd9, 8'h8B, "R10 idle read1");
        read_exp(6'd9, 8'h8B, "R10 idle read2");
        read_exp(6'd9, 8'h8B, "R10 idle read3");

        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule